// File: doc/BRIEF.md
# Reset Pin Glitch Filter

This block cleans up an external, active-low reset pin before it is allowed to raise a reset request inside the chip. The pin can be qualified in one of two clock domains. On the fast bus clock, a programmable 8-bit width sets how long the pin must hold a new level before the filtered request follows. On a slow always-on clock, a fixed rule drops any pulse that lasts fewer than two slow-clock samples. The two filters exclude each other. When neither is on, the synchronised pin passes straight through.

Configuration arrives as single-cycle write commands in the bus domain. Each command names a filter source, an enable or disable operation, a width and a low-power flag. A separate keep-alive bit decides whether the slow filter stays active while the chip is in low-power mode. If the bit is clear, the slow path falls back to the plain synchronised pin in that mode. The current configuration is visible on output ports so the effect of every command can be observed.

The raw pin passes through a two-flop synchroniser in each clock domain. The asynchronous reset is released through a synchroniser per domain.

Top module: `rst_pin_filter`

## Requirements
- R1: A write whose source code is 2 or 3 (0 = bus clock, 1 = slow clock) changes no configuration output, including the low-power keep bit.
- R2: An enable write (cfg_op = 1) for one source clears the other source's enable in the same update, so bus_flt_on and slow_flt_on are never both 1.
- R3: With the bus filter on and width W (0 to 255), rst_req rises only after the synchronised pin has been low for W+1 consecutive bus-clock samples. A shorter low pulse never reaches rst_req.
- R4: With the bus filter on, rst_req falls only after the synchronised pin has been high for W+1 consecutive bus-clock samples. A shorter high glitch during an active request is ignored.
- R5: With the slow filter on, a low pulse seen by fewer than two consecutive slow-clock samples is rejected, and one seen by two or more raises rst_req.
- R6: A disable write (cfg_op = 0) for the bus source clears bus_flt_on and sets bus_width to zero.
- R7: cfg_lp = 1 on an enable write sets lp_keep_on, and on a disable write clears it. While lp_mode = 1 and lp_keep_on = 1, the slow filter still rejects short pulses.
- R8: With both filters off, rst_req is the inverse of the pin, delayed by two bus-clock edges.
- R9: With the slow filter on, lp_mode = 1 and lp_keep_on = 0, rst_req follows the pin synchronised in the slow domain, without filtering.
- R10: During and right after reset, rst_req is 0 and all configuration outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Fast bus clock; also clocks the configuration |
| clk_slow | input | 1 | Slow always-on filter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 1 | Raw external reset pin, active low |
| lp_mode | input | 1 | Chip is in low-power mode |
| cfg_we | input | 1 | Configuration write strobe (bus domain) |
| cfg_op | input | 1 | 1 = enable, 0 = disable |
| cfg_src | input | 2 | 0 = bus-clock filter, 1 = slow-clock filter, others invalid |
| cfg_width | input | 8 | Bus filter width, taken on a bus enable |
| cfg_lp | input | 1 | Also set (enable) or clear (disable) the low-power keep bit |
| bus_flt_on | output | 1 | Bus-clock filter is selected |
| slow_flt_on | output | 1 | Slow-clock filter is selected |
| lp_keep_on | output | 1 | Slow filter stays active in low-power mode |
| bus_width | output | 8 | Current bus filter width |
| rst_req | output | 1 | Filtered reset request, active high |

## Verification
The hardest cases to reach are the ones where the slow filter and low-power mode meet. A pulse has to fall between slow-clock sampling edges while the keep bit and lp_mode select either filtering or pass-through. The bench derives the slow clock from the bus clock, so each slow edge lands on a known bus cycle. It then sizes pulses to cover exactly one or exactly two slow samples, and repeats the same pulse with the keep bit set and then cleared under lp_mode. Bus-filter thresholds are probed with pulses of W and W+1 cycles, including a high glitch inside an active request and the widest 8-bit width.

// File: rtl/rpf_pkg.sv
package rpf_pkg;
  typedef enum logic [1:0] {
    SRC_BUS  = 2'd0,
    SRC_SLOW = 2'd1
  } flt_src_e;

  localparam logic OP_ENABLE  = 1'b1;
  localparam logic OP_DISABLE = 1'b0;
endpackage

// File: rtl/rpf_sync.sv
module rpf_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rpf_filter.sv
module rpf_filter #(
  parameter int   CW      = 8,
  parameter logic RST_LVL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [CW-1:0] width,
  output logic          lvl
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          upd_en;

  // A new level must be seen for width+1 samples in a row; any sample
  // that agrees with the held level restarts the run.
  always_comb begin
    lvl_d = lvl_q;
    cnt_d = '0;
    if (din != lvl_q) begin
      if (cnt_q >= width) begin
        lvl_d = din;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign upd_en = (din != lvl_q) || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= RST_LVL;
      cnt_q <= '0;
    end else if (upd_en) begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign lvl = lvl_q;

  assert_run_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (din == lvl_q) |=> (cnt_q == '0));

  assert_no_early_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> ($past(cnt_q) >= $past(width)));
endmodule

// File: rtl/rpf_cfg.sv
module rpf_cfg
  import rpf_pkg::*;
#(
  parameter int WB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          op,
  input  logic [1:0]    src,
  input  logic [WB-1:0] width_in,
  input  logic          lp,
  output logic          bus_on,
  output logic          slow_on,
  output logic          lp_keep,
  output logic [WB-1:0] width
);
  logic          bus_q, bus_d;
  logic          slow_q, slow_d;
  logic          lp_q, lp_d;
  logic [WB-1:0] w_q, w_d;
  logic          src_ok;
  logic          ld_en;

  assign src_ok = (src == SRC_BUS) || (src == SRC_SLOW);
  assign ld_en  = we && src_ok;

  always_comb begin
    bus_d  = bus_q;
    slow_d = slow_q;
    lp_d   = lp_q;
    w_d    = w_q;
    case (src)
      SRC_BUS: begin
        if (op == OP_ENABLE) begin
          bus_d  = 1'b1;
          slow_d = 1'b0;
          w_d    = width_in;
        end else begin
          bus_d  = 1'b0;
          w_d    = '0;
        end
      end
      SRC_SLOW: begin
        if (op == OP_ENABLE) begin
          slow_d = 1'b1;
          bus_d  = 1'b0;
        end else begin
          slow_d = 1'b0;
        end
      end
      default: ;
    endcase
    if (lp) begin
      lp_d = op;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q  <= 1'b0;
      slow_q <= 1'b0;
      lp_q   <= 1'b0;
      w_q    <= '0;
    end else if (ld_en) begin
      bus_q  <= bus_d;
      slow_q <= slow_d;
      lp_q   <= lp_d;
      w_q    <= w_d;
    end
  end

  assign bus_on  = bus_q;
  assign slow_on = slow_q;
  assign lp_keep = lp_q;
  assign width   = w_q;

  assert_one_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_q && slow_q));

  assert_bad_src_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !src_ok) |=> ($stable(bus_q) && $stable(slow_q) && $stable(lp_q) && $stable(w_q)));

  assert_width_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (src == SRC_BUS) && (op == OP_DISABLE)) |=> (w_q == '0 && !bus_q));
endmodule

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int WB          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SLOW_HOLD   = 1
) (
  input  logic          clk_bus,
  input  logic          clk_slow,
  input  logic          rst_n,
  input  logic          pin_n,
  input  logic          lp_mode,
  input  logic          cfg_we,
  input  logic          cfg_op,
  input  logic [1:0]    cfg_src,
  input  logic [WB-1:0] cfg_width,
  input  logic          cfg_lp,
  output logic          bus_flt_on,
  output logic          slow_flt_on,
  output logic          lp_keep_on,
  output logic [WB-1:0] bus_width,
  output logic          rst_req
);
  localparam int NDOM = 2;
  localparam int DBUS = 0;
  localparam int DSLW = 1;

  logic [NDOM-1:0] dom_clk;
  logic [NDOM-1:0] dom_rst_n;
  logic [NDOM-1:0] dom_pin;
  logic [NDOM-1:0] dom_lvl;
  logic [WB-1:0]   dom_w [NDOM];
  logic            pin_sel;

  assign dom_clk[DBUS] = clk_bus;
  assign dom_clk[DSLW] = clk_slow;
  assign dom_w[DBUS]   = bus_width;
  assign dom_w[DSLW]   = WB'(SLOW_HOLD);

  rpf_cfg #(.WB(WB)) u_cfg (
    .clk      (clk_bus),
    .rst_n    (dom_rst_n[DBUS]),
    .we       (cfg_we),
    .op       (cfg_op),
    .src      (cfg_src),
    .width_in (cfg_width),
    .lp       (cfg_lp),
    .bus_on   (bus_flt_on),
    .slow_on  (slow_flt_on),
    .lp_keep  (lp_keep_on),
    .width    (bus_width)
  );

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    rpf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
      .clk   (dom_clk[d]),
      .rst_n (rst_n),
      .d     (1'b1),
      .q     (dom_rst_n[d])
    );

    rpf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
      .clk   (dom_clk[d]),
      .rst_n (dom_rst_n[d]),
      .d     (pin_n),
      .q     (dom_pin[d])
    );

    rpf_filter #(.CW(WB), .RST_LVL(1'b1)) u_flt (
      .clk   (dom_clk[d]),
      .rst_n (dom_rst_n[d]),
      .din   (dom_pin[d]),
      .width (dom_w[d]),
      .lvl   (dom_lvl[d])
    );
  end

  always_comb begin
    if (bus_flt_on) begin
      pin_sel = dom_lvl[DBUS];
    end else if (slow_flt_on) begin
      pin_sel = (lp_mode && !lp_keep_on) ? dom_pin[DSLW] : dom_lvl[DSLW];
    end else begin
      pin_sel = dom_pin[DBUS];
    end
  end

  assign rst_req = ~pin_sel;
endmodule

// File: tb/sim_rst_pin_filter.sv
module sim_rst_pin_filter;
  logic clk_bus = 1'b0;
  logic clk_slow = 1'b0;
  logic rst_n = 1'b0;
  logic pin_n = 1'b1;
  logic lp_mode = 1'b0;
  logic cfg_we = 1'b0;
  logic cfg_op = 1'b0;
  logic [1:0] cfg_src = 2'd0;
  logic [7:0] cfg_width = 8'd0;
  logic cfg_lp = 1'b0;
  logic bus_flt_on, slow_flt_on, lp_keep_on, rst_req;
  logic [7:0] bus_width;

  int checks = 0;
  int errors = 0;
  int div = 0;
  bit seen = 0;
  bit done = 0;

  always #5 clk_bus = ~clk_bus;

  always @(posedge clk_bus) begin
    if (div == 3) begin
      clk_slow <= ~clk_slow;
      div <= 0;
    end else begin
      div <= div + 1;
    end
  end

  rst_pin_filter u0 (
    .clk_bus(clk_bus), .clk_slow(clk_slow), .rst_n(rst_n), .pin_n(pin_n),
    .lp_mode(lp_mode), .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_src(cfg_src),
    .cfg_width(cfg_width), .cfg_lp(cfg_lp), .bus_flt_on(bus_flt_on),
    .slow_flt_on(slow_flt_on), .lp_keep_on(lp_keep_on), .bus_width(bus_width),
    .rst_req(rst_req)
  );

  // ---------------- behavioural reference ----------------
  int rb_cnt, rs_cnt;
  bit qb[$];
  bit qs[$];
  bit hold_b, hold_s;
  int run_b, run_s;
  bit m_bus, m_slow, m_lp;
  int m_w;

  always @(posedge clk_bus) begin
    if (!rst_n) begin
      rb_cnt = 0; qb = '{1'b1, 1'b1}; hold_b = 1; run_b = 0;
      m_bus = 0; m_slow = 0; m_lp = 0; m_w = 0;
    end else begin
      if (rb_cnt >= 2) begin
        if (qb[0] != hold_b) begin
          if (run_b >= m_w) begin hold_b = qb[0]; run_b = 0; end
          else run_b = run_b + 1;
        end else run_b = 0;
        qb.push_back(pin_n);
        void'(qb.pop_front());
        if (cfg_we && cfg_src < 2) begin
          if (cfg_src == 0) begin
            if (cfg_op) begin m_bus = 1; m_slow = 0; m_w = cfg_width; end
            else begin m_bus = 0; m_w = 0; end
          end else begin
            if (cfg_op) begin m_slow = 1; m_bus = 0; end
            else m_slow = 0;
          end
          if (cfg_lp) m_lp = cfg_op;
        end
      end
      if (rb_cnt < 2) rb_cnt = rb_cnt + 1;
    end
  end

  always @(posedge clk_slow) begin
    if (!rst_n) begin
      rs_cnt = 0; qs = '{1'b1, 1'b1}; hold_s = 1; run_s = 0;
    end else begin
      if (rs_cnt >= 2) begin
        if (qs[0] != hold_s) begin
          if (run_s >= 1) begin hold_s = qs[0]; run_s = 0; end
          else run_s = run_s + 1;
        end else run_s = 0;
        qs.push_back(pin_n);
        void'(qs.pop_front());
      end
      if (rs_cnt < 2) rs_cnt = rs_cnt + 1;
    end
  end

  function automatic bit model_req();
    if (m_bus) return !hold_b;
    if (m_slow) return (lp_mode && !m_lp) ? !qs[0] : !hold_s;
    return !qb[0];
  endfunction

  function automatic string mode_tag();
    if (m_bus) return "R3";
    if (m_slow) return (lp_mode && !m_lp) ? "R9" : "R5";
    return "R8";
  endfunction

  // per-cycle comparison, away from the clock edge
  always @(posedge clk_bus) begin
    #3;
    if (!done) begin
      checks++;
      if (rst_req) seen = 1;
      if (rst_req !== model_req()) begin
        errors++;
        $display("FAIL %s rst_req actual=%0b expected=%0b t=%0t", mode_tag(), rst_req, model_req(), $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input bit op, input int src, input int w, input bit lp);
    @(negedge clk_bus);
    cfg_we = 1; cfg_op = op; cfg_src = src[1:0]; cfg_width = w[7:0]; cfg_lp = lp;
    @(negedge clk_bus);
    cfg_we = 0; cfg_lp = 0;
  endtask

  task automatic pulse(input int len, input int settle);
    @(negedge clk_bus);
    seen = 0;
    pin_n = 0;
    repeat (len) @(negedge clk_bus);
    pin_n = 1;
    repeat (settle) @(negedge clk_bus);
  endtask

  task automatic align_slow();
    // start just after a rising slow edge
    @(posedge clk_slow);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_bus);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk_bus);
    // R10 reset state
    chk(rst_req == 0, "R10 rst_req in reset", rst_req, 0);
    chk({bus_flt_on, slow_flt_on, lp_keep_on} == 0 && bus_width == 0, "R10 cfg in reset",
        {bus_flt_on, slow_flt_on, lp_keep_on}, 0);
    rst_n = 1;
    repeat (6) @(negedge clk_bus);
    chk(rst_req == 0, "R10 rst_req after release", rst_req, 0);

    // R8 pass-through, one-cycle pulse reaches the output
    pulse(1, 6);
    chk(seen == 1, "R8 short pulse passes unfiltered", seen, 1);

    // R3 bus filter width 3
    cfg_write(1, 0, 3, 0);
    chk(bus_flt_on == 1 && bus_width == 3, "R3 bus enable", bus_width, 3);
    pulse(3, 10);
    chk(seen == 0, "R3 pulse of W cycles rejected", seen, 0);
    pulse(4, 10);
    chk(seen == 1, "R3 pulse of W+1 cycles accepted", seen, 1);

    // R4 deassert rule with high glitch inside an active request
    @(negedge clk_bus); pin_n = 0;
    repeat (10) @(negedge clk_bus); pin_n = 1;
    repeat (3) @(negedge clk_bus); pin_n = 0;
    repeat (5) @(negedge clk_bus);
    chk(rst_req == 1, "R4 high glitch ignored", rst_req, 1);
    pin_n = 1;
    repeat (4) @(negedge clk_bus);
    chk(rst_req == 1, "R4 release not yet qualified", rst_req, 1);
    repeat (4) @(negedge clk_bus);
    chk(rst_req == 0, "R4 release after W+1 samples", rst_req, 0);

    // R3 width 0 and width 255
    cfg_write(1, 0, 0, 0);
    pulse(1, 6);
    chk(seen == 1, "R3 width 0 passes one sample", seen, 1);
    cfg_write(1, 0, 255, 0);
    pulse(255, 270);
    chk(seen == 0, "R3 width 255 rejects 255 cycles", seen, 0);
    pulse(256, 270);
    chk(seen == 1, "R3 width 255 accepts 256 cycles", seen, 1);

    // R1 invalid sources ignored
    cfg_write(1, 2, 9, 1);
    chk(bus_flt_on == 1 && slow_flt_on == 0 && lp_keep_on == 0 && bus_width == 255,
        "R1 source 2 ignored", bus_width, 255);
    cfg_write(0, 3, 0, 1);
    chk(bus_flt_on == 1 && bus_width == 255, "R1 source 3 ignored", bus_flt_on, 1);

    // R2 slow enable turns bus filter off
    cfg_write(1, 1, 0, 0);
    chk(slow_flt_on == 1 && bus_flt_on == 0, "R2 slow enable clears bus", bus_flt_on, 0);
    chk(bus_width == 255, "R2 width untouched by slow enable", bus_width, 255);

    // R5 slow filter
    align_slow();
    pulse(8, 40);
    chk(seen == 0, "R5 one slow sample rejected", seen, 0);
    align_slow();
    pulse(16, 40);
    chk(seen == 1, "R5 two slow samples accepted", seen, 1);

    // R2 bus enable turns slow filter off
    cfg_write(1, 0, 5, 0);
    chk(bus_flt_on == 1 && slow_flt_on == 0, "R2 bus enable clears slow", slow_flt_on, 0);

    // R6 bus disable clears width
    cfg_write(0, 0, 77, 0);
    chk(bus_flt_on == 0 && bus_width == 0, "R6 width cleared on disable", bus_width, 0);

    // R7 low-power keep bit
    cfg_write(1, 1, 0, 1);
    chk(lp_keep_on == 1 && slow_flt_on == 1, "R7 keep bit set", lp_keep_on, 1);
    @(negedge clk_bus); lp_mode = 1;
    align_slow();
    pulse(8, 40);
    chk(seen == 0, "R7 slow filter active in low power", seen, 0);

    // R9 keep bit cleared: pass-through in low-power mode
    cfg_write(0, 1, 0, 1);
    chk(lp_keep_on == 0 && slow_flt_on == 0, "R7 keep bit cleared", lp_keep_on, 0);
    cfg_write(1, 1, 0, 0);
    chk(lp_keep_on == 0 && slow_flt_on == 1, "R9 slow on, keep clear", lp_keep_on, 0);
    align_slow();
    pulse(8, 40);
    chk(seen == 1, "R9 short pulse passes in low power", seen, 1);
    @(negedge clk_bus); lp_mode = 0;
    align_slow();
    pulse(8, 40);
    chk(seen == 0, "R5 filter back on leaving low power", seen, 0);

    repeat (4) @(negedge clk_bus);
    finish_run();
  end
endmodule